// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block is the control state machine that sits beside the loop filter of a network clock synchronizer. A three-bit mode select chooses one of three things: tracking one of two references, a forced holdover on one of them, or free-running from the local master oscillator. Each reference arrives with a valid flag. A valid flag is acted on only once its new level has held for a set number of cycles. If the tracked reference is lost while the loop is locked, the machine moves by itself into an automatic holdover for that reference. When the reference returns, the machine goes back to tracking and issues one of two one-cycle commands to the datapath: a phase realignment, or a phase-continuous return through the time-interval-error corrector. A control input picks which.

The outputs tell the frequency storage what to do. The capture strobe refreshes the stored frequency word while the loop is locked to a valid reference. The holdover enable freezes that word in both kinds of holdover. The active-reference output steers the phase detector input. The state is also given out as a three-bit code.

States are FREE (free-run), NORM_P and NORM_S (tracking primary or secondary), HOLD_P and HOLD_S (forced holdover), and AUTO_P and AUTO_S (automatic holdover). The transitions are:
- forced free-run from any state;
- forced holdover from any state;
- normal entry from any state when the selected reference is qualified valid;
- loss in normal, from NORM_x into AUTO_x;
- staying in AUTO_x while the reference stays lost;
- recovery, from AUTO_x into a normal state, carrying the realign or continuity pulse.

Top module: `synmode_ctrl`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, sets the state code to FREE. It also clears the qualified valid flags, and drives ref_sec, hold_en, capture_stb, realign_pulse and tie_pulse to 0.
- R2: State codes are FREE=000, NORM_P=001, NORM_S=010, HOLD_P=011, HOLD_S=100, AUTO_P=101, AUTO_S=110. mode_sel is {bit2, bit1, ref_pick}. When mode_sel[2]=1, the state becomes FREE at the next edge, whatever the valid flags are.
- R3: mode_sel=010 gives HOLD_P and mode_sel=011 gives HOLD_S at the next edge, whatever the valid flags are.
- R4: mode_sel=000 (primary) or 001 (secondary) moves the state to NORM_P or NORM_S at the next edge, from any state, but only if the selected reference is qualified valid.
- R5: With mode_sel 000 or 001 and the selected reference not qualified valid, the state moves as follows. NORM_P and AUTO_P go to AUTO_P. NORM_S and AUTO_S go to AUTO_S. FREE, HOLD_P and HOLD_S keep their state.
- R6: A qualified valid flag takes a new raw level at the STABLE_CYCLES-th consecutive rising edge (default 4) at which the raw level differs from it. A raw pulse that is shorter than this has no effect on the state.
- R7: A move from AUTO_x to a normal state sets one output high for exactly the first cycle of the new state. realign_pulse is used if cont_sel was 0 at that edge, and tie_pulse if it was 1. The two pulses are never high together, and no other transition produces either one.
- R8: hold_en is 1 exactly in HOLD_P, HOLD_S, AUTO_P and AUTO_S.
- R9: capture_stb is 1 exactly when the state is NORM_P with the primary reference qualified valid, or NORM_S with the secondary reference qualified valid. It is therefore 0 in FREE.
- R10: ref_sec is 1 in NORM_S, HOLD_S and AUTO_S, and 0 in all other states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 3 | Mode select {bit2, bit1, ref_pick} |
| pri_ok | input | 1 | Primary reference valid, already synchronized |
| sec_ok | input | 1 | Secondary reference valid, already synchronized |
| cont_sel | input | 1 | Recovery style: 0 realign, 1 phase-continuous |
| state_code | output | 3 | Current state code |
| ref_sec | output | 1 | Active reference is secondary |
| hold_en | output | 1 | Freeze the stored frequency word |
| capture_stb | output | 1 | Refresh the stored frequency word |
| realign_pulse | output | 1 | One-cycle phase realignment command |
| tie_pulse | output | 1 | One-cycle phase-continuity correction command |

## Verification
The recovery pulses are the hardest outputs to reach. They need a normal state to be entered first. Then the raw valid flag must stay low long enough to pass the stability filter and push the machine into automatic holdover, and then stay high long enough to requalify. The stimulus walks this path twice, once with each cont_sel value. It also sends raw glitches one cycle short of the filter length, and checks that neither a holdover nor a pulse follows.

// File: rtl/synmode_pkg.sv
package synmode_pkg;

    typedef enum logic [2:0] {
        ST_FREE   = 3'd0,
        ST_NORM_P = 3'd1,
        ST_NORM_S = 3'd2,
        ST_HOLD_P = 3'd3,
        ST_HOLD_S = 3'd4,
        ST_AUTO_P = 3'd5,
        ST_AUTO_S = 3'd6
    } sync_state_e;

    localparam int NUM_REFS = 2;
    localparam int REF_PRI  = 0;
    localparam int REF_SEC  = 1;

    function automatic logic is_auto(input sync_state_e s);
        return (s == ST_AUTO_P) || (s == ST_AUTO_S);
    endfunction

    function automatic logic is_norm(input sync_state_e s);
        return (s == ST_NORM_P) || (s == ST_NORM_S);
    endfunction

endpackage

// File: rtl/synmode_ref_qual.sv
module synmode_ref_qual #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_ok,
    output logic qual_ok
);
    localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            qual_ok <= 1'b0;
            run_cnt <= '0;
        end else if (raw_ok == qual_ok) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            qual_ok <= raw_ok;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R6: the filtered level only ever moves toward the raw level just seen
    a_r6_follows_raw: assert property (@(posedge clk) disable iff (rst)
        !$stable(qual_ok) |-> (qual_ok == $past(raw_ok)));

endmodule

// File: rtl/synmode_fsm.sv
module synmode_fsm
    import synmode_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          mode_sel,
    input  logic [NUM_REFS-1:0] ok_q,
    input  logic                cont_sel,
    output sync_state_e         cur,
    output logic                realign_pulse,
    output logic                tie_pulse
);
    sync_state_e nxt;
    logic        sel_ok;
    logic        recover;

    always_comb begin
        sel_ok = mode_sel[0] ? ok_q[REF_SEC] : ok_q[REF_PRI];
        nxt    = cur;
        if (mode_sel[2]) begin
            nxt = ST_FREE;
        end else if (mode_sel[1]) begin
            nxt = mode_sel[0] ? ST_HOLD_S : ST_HOLD_P;
        end else if (sel_ok) begin
            nxt = mode_sel[0] ? ST_NORM_S : ST_NORM_P;
        end else begin
            unique case (cur)
                ST_NORM_P, ST_AUTO_P: nxt = ST_AUTO_P;
                ST_NORM_S, ST_AUTO_S: nxt = ST_AUTO_S;
                default:              nxt = cur;
            endcase
        end
    end

    assign recover = is_auto(cur) && is_norm(nxt);

    // state register
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_FREE;
        else     cur <= nxt;
    end

    // registered command outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            realign_pulse <= 1'b0;
            tie_pulse     <= 1'b0;
        end else begin
            realign_pulse <= recover && !cont_sel;
            tie_pulse     <= recover &&  cont_sel;
        end
    end

    a_r2_forced_free: assert property (@(posedge clk) disable iff (rst)
        mode_sel[2] |=> (cur == ST_FREE));

    a_r3_forced_hold_p: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 3'b010) |=> (cur == ST_HOLD_P));

    a_r4_entry_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_NORM_P && $past(cur) != ST_NORM_P) |-> $past(ok_q[REF_PRI]));

    a_r7_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({realign_pulse, tie_pulse}));

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (realign_pulse || tie_pulse) |=> !(realign_pulse || tie_pulse));

    a_r7_pulse_after_auto: assert property (@(posedge clk) disable iff (rst)
        (realign_pulse || tie_pulse) |-> is_auto($past(cur)));

endmodule

// File: rtl/synmode_outdec.sv
module synmode_outdec
    import synmode_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  sync_state_e         cur,
    input  logic [NUM_REFS-1:0] ok_q,
    output logic [2:0]          state_code,
    output logic                ref_sec,
    output logic                hold_en,
    output logic                capture_stb
);
    always_comb begin
        state_code  = cur;
        ref_sec     = 1'b0;
        hold_en     = 1'b0;
        capture_stb = 1'b0;
        unique case (cur)
            ST_FREE:   ;
            ST_NORM_P: capture_stb = ok_q[REF_PRI];
            ST_NORM_S: begin ref_sec = 1'b1; capture_stb = ok_q[REF_SEC]; end
            ST_HOLD_P: hold_en = 1'b1;
            ST_HOLD_S: begin ref_sec = 1'b1; hold_en = 1'b1; end
            ST_AUTO_P: hold_en = 1'b1;
            ST_AUTO_S: begin ref_sec = 1'b1; hold_en = 1'b1; end
            default:   ;
        endcase
    end

    // R8 / R9: the word is never frozen and refreshed in the same cycle
    a_r8_hold_excl_capture: assert property (@(posedge clk) disable iff (rst)
        hold_en |-> !capture_stb);

endmodule

// File: rtl/synmode_ctrl.sv
module synmode_ctrl
    import synmode_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  logic       pri_ok,
    input  logic       sec_ok,
    input  logic       cont_sel,
    output logic [2:0] state_code,
    output logic       ref_sec,
    output logic       hold_en,
    output logic       capture_stb,
    output logic       realign_pulse,
    output logic       tie_pulse
);
    logic [NUM_REFS-1:0] raw_ok;
    logic [NUM_REFS-1:0] ok_q;
    sync_state_e         cur;

    assign raw_ok = {sec_ok, pri_ok};

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
        synmode_ref_qual #(.STABLE_CYCLES(STABLE_CYCLES)) u_qual (
            .clk     (clk),
            .rst     (rst),
            .raw_ok  (raw_ok[g]),
            .qual_ok (ok_q[g])
        );
    end

    synmode_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .mode_sel      (mode_sel),
        .ok_q          (ok_q),
        .cont_sel      (cont_sel),
        .cur           (cur),
        .realign_pulse (realign_pulse),
        .tie_pulse     (tie_pulse)
    );

    synmode_outdec u_dec (
        .clk         (clk),
        .rst         (rst),
        .cur         (cur),
        .ok_q        (ok_q),
        .state_code  (state_code),
        .ref_sec     (ref_sec),
        .hold_en     (hold_en),
        .capture_stb (capture_stb)
    );

endmodule

// File: tb/synmode_ctrl_bench.sv
`timescale 1ns/1ps
module synmode_ctrl_bench;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'b100;
    logic       pri_ok = 1'b0, sec_ok = 1'b0, cont_sel = 1'b0;
    logic [2:0] state_code;
    logic       ref_sec, hold_en, capture_stb, realign_pulse, tie_pulse;

    always #2 clk = ~clk;

    synmode_ctrl #(.STABLE_CYCLES(N)) u_synmode_ctrl (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .pri_ok(pri_ok),
        .sec_ok(sec_ok), .cont_sel(cont_sel), .state_code(state_code),
        .ref_sec(ref_sec), .hold_en(hold_en), .capture_stb(capture_stb),
        .realign_pulse(realign_pulse), .tie_pulse(tie_pulse)
    );

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // reference model state
    int m_st = 0;
    int m_q[2] = '{0, 0};
    int m_cnt[2] = '{0, 0};

    task automatic chk(string tag, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // advance the model by one edge using the inputs now driven, push result
    task automatic step(string tag);
        int raw[2];
        int nx, sel, ra, ti;
        logic [7:0] e;
        raw[0] = pri_ok; raw[1] = sec_ok;
        sel = mode_sel[0] ? m_q[1] : m_q[0];
        nx = m_st;
        if (mode_sel[2]) nx = 0;
        else if (mode_sel[1]) nx = mode_sel[0] ? 4 : 3;
        else if (sel != 0) nx = mode_sel[0] ? 2 : 1;
        else if (m_st == 1 || m_st == 5) nx = 5;
        else if (m_st == 2 || m_st == 6) nx = 6;
        ra = ((m_st == 5 || m_st == 6) && (nx == 1 || nx == 2) && !cont_sel) ? 1 : 0;
        ti = ((m_st == 5 || m_st == 6) && (nx == 1 || nx == 2) &&  cont_sel) ? 1 : 0;
        m_st = nx;
        for (int i = 0; i < 2; i++) begin
            if (raw[i] == m_q[i]) m_cnt[i] = 0;
            else if (m_cnt[i] == N-1) begin m_q[i] = raw[i]; m_cnt[i] = 0; end
            else m_cnt[i]++;
        end
        e[2:0] = 3'(m_st);
        e[3] = (m_st == 2 || m_st == 4 || m_st == 6);
        e[4] = (m_st >= 3);
        e[5] = (m_st == 1 && m_q[0] != 0) || (m_st == 2 && m_q[1] != 0);
        e[6] = 1'(ra);
        e[7] = 1'(ti);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // monitor: compares each edge's result with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t,     state_code,    e[2:0], "state_code");
                chk("R10", ref_sec,       e[3],   "ref_sec");
                chk("R8",  hold_en,       e[4],   "hold_en");
                chk("R9",  capture_stb,   e[5],   "capture_stb");
                chk("R7",  realign_pulse, e[6],   "realign_pulse");
                chk("R7",  tie_pulse,     e[7],   "tie_pulse");
            end
        end
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", state_code, 0, "state_code");
        chk("R1", {ref_sec, hold_en, capture_stb, realign_pulse, tie_pulse}, 0, "outputs");
        rst = 1'b0;
        // R2: free-run while references qualify
        pri_ok = 1; sec_ok = 1; mode_sel = 3'b100;
        run("R2", 6);
        // R4: enter normal primary
        mode_sel = 3'b000;
        run("R4", 4);
        // R6: glitch shorter than filter is ignored
        pri_ok = 0; run("R6", N-1);
        pri_ok = 1; run("R6", 4);
        // R5: loss goes to auto-holdover; R7 realign on return
        pri_ok = 0; cont_sel = 0; run("R5", 8);
        pri_ok = 1; run("R7", 8);
        // R7: continuity return
        pri_ok = 0; cont_sel = 1; run("R5", 8);
        pri_ok = 1; run("R7", 8);
        // R4 / R5 on secondary
        mode_sel = 3'b001; run("R4", 3);
        sec_ok = 0; run("R5", 7);
        // R3: forced holdover overrides validity
        mode_sel = 3'b010; run("R3", 3);
        mode_sel = 3'b011; run("R3", 3);
        // R5: normal select with invalid reference keeps forced holdover
        pri_ok = 0; mode_sel = 3'b011; run("R5", 6);
        mode_sel = 3'b000; run("R5", 4);
        // R4: entry from holdover once valid, no pulse (R7)
        pri_ok = 1; run("R4", 7);
        // R2: free-run with references invalid
        pri_ok = 0; sec_ok = 0; mode_sel = 3'b101; run("R2", 7);
        // R5: free-run stays when selected reference invalid
        mode_sel = 3'b001; run("R5", 4);
        sec_ok = 1; run("R4", 7);
        // R1: reset again from a normal state
        rst = 1'b1; @(negedge clk);
        chk("R1", state_code, 0, "state_code after reset");
        chk("R1", capture_stb, 0, "capture after reset");
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule